// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for a high-precision event timer. A shared free-running main counter is fed in from outside; the channel holds a comparator value and, each cycle, decides whether the counter has just arrived at it. When it has, the channel raises an interrupt request. The channel can run as a one-shot (the comparator stays put after a firing) or as a periodic source (the comparator is pushed forward by a programmed period after each firing). A narrow mode restricts the comparator, the period and all ahead/behind decisions to the low 32 bits.

Software programs the channel through three write strobes: one for a small configuration byte and one each for the low and high words of the comparator. In periodic mode a comparator write normally changes the period instead of the match value. A self-clearing set-value bit in the configuration makes the next comparator write also reach the match value. The request comes out either as a level backed by a status bit, which a clear strobe acknowledges, or as a single-cycle pulse.

Configuration byte layout (`wrData[7:0]` on a configuration write, `cfgView` on readback): bit 0 level style, bit 1 channel enable, bit 2 periodic, bit 3 narrow (32-bit) mode, bit 4 set-value, bit 5 periodic-capable (always 1), bit 6 wide-capable (always 1), bit 7 always 0.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period is zero, `cfgView` reads 0x60, and `irqReq` and `statusBit` are low.
- R2: An enabled channel fires in the cycle after the one in which the sampled counter first equals the comparator. A channel enabled or reprogrammed with its comparator already behind the counter fires only when the counter reaches it again. A one-shot channel never moves its own comparator.
- R3: In level style (bit 0 = 1) a firing sets `statusBit`, `irqReq` follows `statusBit`, and both stay high until a `stsClr` strobe or a disable. A firing in the same cycle as `stsClr` wins.
- R4: In edge style (bit 0 = 0) a firing gives a one-cycle `irqReq` pulse and leaves `statusBit` clear.
- R5: While the global enable or the channel enable (bit 1) is low, nothing fires, and `statusBit` and `irqReq` are low from the next cycle on.
- R6: In periodic mode (bit 2 = 1) a firing adds the period to the comparator. If the counter has already passed the new value, the comparator keeps advancing by one period per cycle until it is ahead. In this catch-up phase the channel does not fire.
- R7: In periodic mode, with set-value clear, a low-word write loads the low period word and a high-word write loads the high period word, and the comparator is unchanged. With set-value set, a low-word write loads both the comparator and period low words, and a high-word write loads only the comparator high word.
- R8: Set-value (bit 4) is cleared by any write to either comparator word.
- R9: The period's top bit is forced to zero: bit 63 on high-word loads, and bit 31 on low-word loads in narrow mode.
- R10: A configuration write with narrow mode (bit 3) set clears the upper 32 bits of the comparator and of the period. In narrow mode, high-word writes change nothing, the comparator's upper word stays zero, and matching and ahead/behind use only the low 32 bits, with a signed 32-bit difference.
- R11: A narrow one-shot channel also fires when the low 32 bits of the counter read 0xFFFFFFFF.
- R12: Bits 5 and 6 of `cfgView` always read 1 and bit 7 always reads 0, whatever is written. A configuration write stores bits 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mainCount | input | 64 | Shared main counter value |
| globalEn | input | 1 | Global timer enable |
| cfgWr | input | 1 | Configuration byte write strobe |
| cmpLoWr | input | 1 | Comparator low-word write strobe |
| cmpHiWr | input | 1 | Comparator high-word write strobe |
| stsClr | input | 1 | Acknowledge: clears the level status bit |
| wrData | input | 32 | Write data for all strobes |
| irqReq | output | 1 | Interrupt request (level or pulse) |
| irqLevel | output | 1 | High when the request is level style |
| statusBit | output | 1 | Level-style pending status |
| cfgView | output | 8 | Configuration byte readback |
| cmpView | output | 64 | Current comparator value |

## Verification
The assertions assume that at most one of `cfgWr`, `cmpLoWr` and `cmpHiWr` is high in any cycle. The set-value and comparator-stability properties would not hold if a configuration write and a comparator write landed together. The stimulus issues every write as a separate one-cycle strobe with the counter held still, and moves the counter only between writes. It also makes deliberate jumps, so that catch-up and the narrow-mode wrap point are reached within a short run.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

  localparam int CFG_W     = 8;
  localparam int B_LEVEL   = 0;
  localparam int B_EN      = 1;
  localparam int B_PER     = 2;
  localparam int B_NARROW  = 3;
  localparam int B_SETVAL  = 4;
  localparam int B_PERCAP  = 5;
  localparam int B_WIDECAP = 6;

  localparam logic [CFG_W-1:0] CAP_BITS = CFG_W'((1 << B_PERCAP) | (1 << B_WIDECAP));
  localparam logic [CFG_W-1:0] WR_MASK  = CFG_W'((1 << (B_SETVAL + 1)) - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic ldCmpLo;
    logic ldCmpHi;
    logic ldPerLo;
    logic ldPerHi;
    logic advance;
    logic truncate;
    logic narrow;
  } strobe_t;

endpackage

// File: rtl/evt_cmp_dpath.sv
module evt_cmp_dpath
  import evt_cmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               stb,
  input  logic [WORD_W-1:0]     wrData,
  input  logic [2*WORD_W-1:0]   mainCount,
  output logic                  isEqual,
  output logic                  isBehind,
  output logic                  lowAllOnes,
  output logic                  periodNz,
  output logic [2*WORD_W-1:0]   cmpVal
);

  localparam int CNT_W = 2 * WORD_W;
  localparam logic [WORD_W-1:0] MSB_OFF = {1'b0, {(WORD_W-1){1'b1}}};

  logic [CNT_W-1:0]  cmpQ;
  logic [CNT_W-1:0]  perQ;
  logic [CNT_W-1:0]  fullDiff;
  logic [WORD_W-1:0] lowDiff;
  logic [CNT_W-1:0]  sumRaw;
  logic [CNT_W-1:0]  sumTrim;
  logic [WORD_W-1:0] perLoIn;

  always_comb begin
    fullDiff   = cmpQ - mainCount;
    lowDiff    = cmpQ[WORD_W-1:0] - mainCount[WORD_W-1:0];
    isEqual    = stb.narrow ? (lowDiff == '0) : (fullDiff == '0);
    isBehind   = stb.narrow ? lowDiff[WORD_W-1] : fullDiff[CNT_W-1];
    lowAllOnes = &mainCount[WORD_W-1:0];
    periodNz   = |perQ;
    sumRaw     = cmpQ + perQ;
    sumTrim    = stb.narrow ? {{WORD_W{1'b0}}, sumRaw[WORD_W-1:0]} : sumRaw;
    perLoIn    = stb.narrow ? (wrData & MSB_OFF) : wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpQ <= '1;
      perQ <= '0;
    end else if (stb.truncate) begin
      cmpQ <= {{WORD_W{1'b0}}, cmpQ[WORD_W-1:0]};
      perQ <= {{WORD_W{1'b0}}, perQ[WORD_W-1:0]};
    end else begin
      if (stb.ldCmpLo) cmpQ[WORD_W-1:0]     <= wrData;
      if (stb.ldCmpHi) cmpQ[CNT_W-1:WORD_W] <= wrData;
      if (stb.ldPerLo) perQ[WORD_W-1:0]     <= perLoIn;
      if (stb.ldPerHi) perQ[CNT_W-1:WORD_W] <= wrData & MSB_OFF;
      if (stb.advance) cmpQ                 <= sumTrim;
    end
  end

  assign cmpVal = cmpQ;

endmodule

// File: rtl/evt_cmp_ctrl.sv
module evt_cmp_ctrl
  import evt_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             globalEn,
  input  logic             cfgWr,
  input  logic             cmpLoWr,
  input  logic             cmpHiWr,
  input  logic             stsClr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             isEqual,
  input  logic             isBehind,
  input  logic             lowAllOnes,
  input  logic             periodNz,
  output strobe_t          stb,
  output logic             irqReq,
  output logic             irqLevel,
  output logic             statusBit,
  output logic [CFG_W-1:0] cfgView
);

  logic [CFG_W-1:0] cfgQ;
  logic hitPrev, catchQ, statusQ, pulseQ;
  logic active, periodic, narrow, setVal, levelMode;
  logic anyCmpWr, anyWr, hit, fire;

  always_comb begin
    active    = globalEn & cfgQ[B_EN];
    periodic  = cfgQ[B_PER];
    narrow    = cfgQ[B_NARROW];
    setVal    = cfgQ[B_SETVAL];
    levelMode = cfgQ[B_LEVEL];
    anyCmpWr  = cmpLoWr | cmpHiWr;
    anyWr     = anyCmpWr | cfgWr;
    hit       = isEqual | (narrow & ~periodic & lowAllOnes);
    fire      = active & hit & ~hitPrev;

    stb.ldCmpLo  = cmpLoWr & (~periodic | setVal);
    stb.ldPerLo  = cmpLoWr & periodic;
    stb.ldCmpHi  = cmpHiWr & ~narrow & (~periodic | setVal);
    stb.ldPerHi  = cmpHiWr & ~narrow & periodic & ~setVal;
    stb.truncate = cfgWr & cfgData[B_NARROW];
    stb.narrow   = narrow;
    stb.advance  = active & ~anyWr & periodic &
                   (fire | (catchQ & isBehind & periodNz));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ    <= CAP_BITS;
      hitPrev <= 1'b0;
      catchQ  <= 1'b0;
      statusQ <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      if (cfgWr)         cfgQ <= (cfgData & WR_MASK) | CAP_BITS;
      else if (anyCmpWr) cfgQ[B_SETVAL] <= 1'b0;

      hitPrev <= hit;

      if (!active || anyWr)                      catchQ <= 1'b0;
      else if (fire && periodic)                 catchQ <= 1'b1;
      else if (catchQ && !(isBehind && periodNz)) catchQ <= 1'b0;

      if (!active)     statusQ <= 1'b0;
      else if (fire)   statusQ <= levelMode;
      else if (stsClr) statusQ <= 1'b0;

      pulseQ <= fire & ~levelMode;
    end
  end

  assign irqReq    = levelMode ? statusQ : pulseQ;
  assign irqLevel  = levelMode;
  assign statusBit = statusQ;
  assign cfgView   = cfgQ;

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*WORD_W-1:0] mainCount,
  input  logic                globalEn,
  input  logic                cfgWr,
  input  logic                cmpLoWr,
  input  logic                cmpHiWr,
  input  logic                stsClr,
  input  logic [WORD_W-1:0]   wrData,
  output logic                irqReq,
  output logic                irqLevel,
  output logic                statusBit,
  output logic [CFG_W-1:0]    cfgView,
  output logic [2*WORD_W-1:0] cmpView
);

  strobe_t stb;
  logic isEqual, isBehind, lowAllOnes, periodNz;

  evt_cmp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .globalEn   (globalEn),
    .cfgWr      (cfgWr),
    .cmpLoWr    (cmpLoWr),
    .cmpHiWr    (cmpHiWr),
    .stsClr     (stsClr),
    .cfgData    (wrData[CFG_W-1:0]),
    .isEqual    (isEqual),
    .isBehind   (isBehind),
    .lowAllOnes (lowAllOnes),
    .periodNz   (periodNz),
    .stb        (stb),
    .irqReq     (irqReq),
    .irqLevel   (irqLevel),
    .statusBit  (statusBit),
    .cfgView    (cfgView)
  );

  evt_cmp_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wrData     (wrData),
    .mainCount  (mainCount),
    .isEqual    (isEqual),
    .isBehind   (isBehind),
    .lowAllOnes (lowAllOnes),
    .periodNz   (periodNz),
    .cmpVal     (cmpView)
  );

endmodule

// File: rtl/evt_cmp_chk.sv
module evt_cmp_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                globalEn,
  input logic                cfgWr,
  input logic                cmpLoWr,
  input logic                cmpHiWr,
  input logic                stsClr,
  input logic                irqReq,
  input logic                irqLevel,
  input logic                statusBit,
  input logic [7:0]          cfgView,
  input logic [2*WORD_W-1:0] cmpView
);

  localparam int CNT_W = 2 * WORD_W;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(globalEn && cfgView[1]) |=> (!statusBit && !irqReq)); // R5

  AST_SETVAL_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpLoWr || cmpHiWr) |=> !cfgView[4]); // R8

  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfgView[3] |-> (cmpView[CNT_W-1:WORD_W] == '0)); // R10

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq && !irqLevel) |=> !(irqReq && !irqLevel)); // R4

  AST_EDGE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq && !irqLevel) |-> !statusBit); // R4

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (statusBit && cfgView[0] && globalEn && cfgView[1] && !stsClr) |=> statusBit); // R3

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irqLevel |-> (irqReq == statusBit)); // R3

  AST_ONESHOT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgView[2] && !cfgWr && !cmpLoWr && !cmpHiWr) |=> $stable(cmpView)); // R2

  AST_CAPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cfgView[7:5] == 3'b011); // R12

endmodule

bind evt_cmp_channel evt_cmp_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_evt_cmp_channel.sv
module tb_evt_cmp_channel;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        gEn = 1'b0, cfgWr = 1'b0, loWr = 1'b0, hiWr = 1'b0, clr = 1'b0;
  logic [31:0] wd = '0;
  logic        irqReq, irqLevel, statusBit;
  logic [7:0]  cfgView;
  logic [63:0] cmpView;

  evt_cmp_channel dut (
    .clk(clk), .rst_n(rst_n), .mainCount(cnt), .globalEn(gEn),
    .cfgWr(cfgWr), .cmpLoWr(loWr), .cmpHiWr(hiWr), .stsClr(clr), .wrData(wd),
    .irqReq(irqReq), .irqLevel(irqLevel), .statusBit(statusBit),
    .cfgView(cfgView), .cmpView(cmpView)
  );

  int    total = 0, bad = 0, cycles = 0;
  string curReq = "R1";
  bit    started = 0, finished = 0;

  // behavioural reference
  logic [7:0]  mCfg;
  logic [63:0] mCmp, mPer;
  bit mHitPrev, mCatch, mStatus, mPulse;
  bit act, nar, per, sv, lvl, hit, fire, behind, anyW;

  always @(posedge clk) begin : refModel
    if (!rst_n) begin
      mCfg = 8'h60; mCmp = '1; mPer = '0;
      mHitPrev = 0; mCatch = 0; mStatus = 0; mPulse = 0;
    end else begin
      act  = gEn && mCfg[1];
      lvl  = mCfg[0]; per = mCfg[2]; nar = mCfg[3]; sv = mCfg[4];
      anyW = cfgWr || loWr || hiWr;
      if (nar) begin
        hit    = (mCmp[31:0] == cnt[31:0]) || (!per && cnt[31:0] == 32'hFFFF_FFFF);
        behind = int'(mCmp[31:0] - cnt[31:0]) < 0;
      end else begin
        hit    = (mCmp == cnt);
        behind = longint'(mCmp - cnt) < 0;
      end
      fire = act && hit && !mHitPrev;
      mHitPrev = hit;
      mPulse = fire && !lvl;
      if (!act) mStatus = 0;
      else if (fire) mStatus = lvl;
      else if (clr) mStatus = 0;
      if (cfgWr) begin
        mCfg = (wd[7:0] & 8'h1F) | 8'h60;
        if (wd[3]) begin mCmp = mCmp & 64'hFFFF_FFFF; mPer = mPer & 64'hFFFF_FFFF; end
      end else if (loWr) begin
        if (!per || sv) mCmp[31:0] = wd;
        if (per) mPer[31:0] = nar ? (wd & 32'h7FFF_FFFF) : wd;
        mCfg[4] = 0;
      end else if (hiWr) begin
        if (!nar) begin
          if (!per || sv) mCmp[63:32] = wd;
          else mPer[63:32] = wd & 32'h7FFF_FFFF;
        end
        mCfg[4] = 0;
      end else if (act && per && (fire || (mCatch && behind && mPer != 0))) begin
        mCmp = mCmp + mPer;
        if (nar) mCmp[63:32] = '0;
      end
      if (!act || anyW) mCatch = 0;
      else if (fire && per) mCatch = 1;
      else if (mCatch && !(behind && mPer != 0)) mCatch = 0;
    end
  end

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at t=%0t", curReq, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("cfgView", cfgView, mCfg);
      chk("cmpView", cmpView, mCmp);
      chk("statusBit", statusBit, mStatus);
      chk("irqLevel", irqLevel, mCfg[0]);
      chk("irqReq", irqReq, mCfg[0] ? mStatus : mPulse);
    end
  end

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      summary();
    end
  end

  task automatic cyc(int n, longint unsigned inc);
    repeat (n) begin @(negedge clk); #1 cnt = cnt + inc; end
  endtask
  task automatic setCnt(logic [63:0] v);
    @(negedge clk); #1 cnt = v;
  endtask
  task automatic strobe(int which, logic [31:0] d);
    @(negedge clk); #1 wd = d;
    case (which)
      0: cfgWr = 1; 1: loWr = 1; 2: hiWr = 1; default: clr = 1;
    endcase
    @(negedge clk); #1 cfgWr = 0; loWr = 0; hiWr = 0; clr = 0;
  endtask
  task automatic xchk(string what, logic [63:0] got, logic [63:0] exp);
    @(negedge clk);
    chk(what, got, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1; gEn = 1; started = 1;
    // R1 reset state
    curReq = "R1";
    xchk("reset cmp", cmpView, '1);
    xchk("reset cfg", {56'd0, cfgView}, 64'h60);
    xchk("reset irq", {62'd0, irqReq, statusBit}, 64'd0);

    // R12 capability bits read-only
    curReq = "R12";
    strobe(0, 32'hE0);
    xchk("cfg after E0", {56'd0, cfgView}, 64'h60);

    // R2/R3 level one-shot
    curReq = "R2";
    setCnt(10); strobe(1, 20); strobe(2, 0); strobe(0, 32'h03);
    cyc(15, 1);
    curReq = "R3";
    xchk("level status", {63'd0, statusBit}, 64'd1);
    cyc(3, 1);
    strobe(3, 0);
    xchk("cleared", {63'd0, statusBit}, 64'd0);
    curReq = "R2";
    setCnt(50); strobe(1, 30); cyc(10, 1);
    xchk("behind no fire", {63'd0, statusBit}, 64'd0);

    // R4 edge
    curReq = "R4";
    strobe(0, 32'h02); strobe(1, 70); setCnt(65); cyc(12, 1);

    // R5 disable
    curReq = "R5";
    strobe(0, 32'h03); strobe(1, 90); setCnt(85); cyc(8, 1);
    @(negedge clk); #1 gEn = 0;
    cyc(2, 0);
    xchk("disabled status", {63'd0, statusBit}, 64'd0);
    setCnt(95); strobe(1, 100); cyc(10, 1);
    @(negedge clk); #1 gEn = 1;
    cyc(2, 1);

    // R7/R8/R6 periodic
    curReq = "R8";
    strobe(0, 32'h16);
    xchk("setval armed", {63'd0, cfgView[4]}, 64'd1);
    curReq = "R7";
    strobe(1, 100); strobe(2, 0); strobe(1, 10);
    curReq = "R6";
    setCnt(95); cyc(30, 1); cyc(5, 1);
    setCnt(165); cyc(5, 0); cyc(10, 1);

    // R9 period top bit
    curReq = "R9";
    strobe(0, 32'h16); strobe(1, 200); strobe(2, 32'hFFFF_FFFF);
    setCnt(195); cyc(8, 1);
    xchk("wide period msb", cmpView, 64'h7FFF_FFFF_0000_0190);
    curReq = "R10";
    strobe(0, 32'h1E);
    xchk("truncate", cmpView, 64'h190);
    curReq = "R9";
    strobe(1, 32'hFFFF_FFF0);
    setCnt(64'h3_FFFF_FFEC); cyc(8, 1);
    xchk("narrow period msb", cmpView, 64'h7FFF_FFE0);

    // R10 narrow one-shot compare
    curReq = "R10";
    strobe(0, 32'h0A); strobe(1, 32'h50); strobe(2, 32'h1234);
    xchk("hi ignored", cmpView, 64'h50);
    setCnt(64'h5_0000_0040); cyc(20, 1);

    // R11 wrap firing
    curReq = "R11";
    strobe(0, 32'h0B); strobe(1, 32'h10);
    setCnt(64'h7_FFFF_FFF8); cyc(10, 1);
    xchk("wrap status", {63'd0, statusBit}, 64'd1);
    strobe(3, 0); cyc(20, 1);

    cyc(3, 0);
    summary();
  end

endmodule